// File: doc/BRIEF.md
# Batch RAM FIR Engine

This block runs a 51-tap finite impulse response filter over a whole batch of samples that already sit in on-chip memory, not over a live stream. The host first writes the tap weights into a register file and the samples into a banked sample memory, using two simple write ports. It then pulses `start`. The engine walks through every output index. For each output it evaluates the taps in groups of `LANES`, with one multiplier per lane, and it stores each finished 38-bit result in an output memory. When the last result has been written it pulses `done`, and the host reads the results back through a registered read port.

Samples and weights are signed two's complement, 16 bits wide. Sample positions below index 0 count as zero, so output n draws only on samples 0 through n. The sample memory is split into `LANES` banks, interleaved by the low address bits. As a result, the `LANES` consecutive samples that one tap group needs always fall in distinct banks, and each bank serves one read per cycle.

Top module: `batch_fir`

## Requirements
- R1: Once reset is released, `busy` and `done` are low and `rdData` reads zero.
- R2: Once a batch has finished, output n equals the sum over k = 0..50 of w[k]*x[n-k], where w[k] is the weight written at `coefIdx` = k and x[i] is the sample written at `smpAddr` = i. Any x with a negative index counts as zero.
- R3: Results are kept at the full signed 38-bit width. When every weight and every sample sits at the 16-bit extremes (-32768 or +32767), the result is exact and does not wrap.
- R4: A `start` pulse that arrives while `busy` is high has no effect. The batch in progress keeps its length and its results.
- R5: `done` goes high on the clock edge that lies LEN*G+2 edges after the edge that accepted `start`. Here G = ceil(51/LANES), which gives 3330 with the defaults. `done` stays high for exactly one cycle.
- R6: `busy` rises on the edge that accepts `start`. It stays high until the edge on which `done` rises, and on that same edge it falls.
- R7: `rdData` shows the result stored at `rdAddr` one clock edge after `rdAddr` is presented.
- R8: Weight index k multiplies the sample k positions earlier. Loading a single unit sample at index 0 therefore yields output n = w[n] for n < 51, and 0 for every later n.
- R9: A weight write whose `coefIdx` is 51 or higher is discarded and leaves every result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coefWe | input | 1 | Weight write strobe |
| coefIdx | input | 6 | Tap index of the weight being written |
| coefData | input | 16 | Signed weight value |
| smpWe | input | 1 | Sample write strobe |
| smpAddr | input | 8 | Sample index being written |
| smpData | input | 16 | Signed sample value |
| start | input | 1 | Begins a batch when idle |
| busy | output | 1 | High while a batch is running |
| done | output | 1 | One-cycle pulse once all results are stored |
| rdAddr | input | 8 | Result read index |
| rdData | output | 38 | Signed result at `rdAddr`, one cycle later |

## Verification
A lane routed to the wrong bank, or a mask that is off by one, corrupts specific output indices. The impulse batch shows such faults at the first few outputs, because there every tap lands on a known, distinct value. A group counter or output counter with a fault, or a restart while busy, moves the `done` edge away from its fixed count of 3330 edges. This shows up on the very batch in which it occurs. A truncated accumulator appears in the extreme-value batches as a sign flip or a wrapped magnitude on every output from index 50 onward.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;

  // Strobes from the sequencer to the arithmetic pipeline.
  typedef struct packed {
    logic issue;   // one tap group is being read this cycle
    logic first;   // first group of an output: clear the accumulator
    logic last;    // last group of an output: store the result
  } fir_strobe_t;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int safeLog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/fir_ctrl.sv
`timescale 1ns/1ps
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int LEN    = 256,
  parameter int GROUPS = 13,
  localparam int OW    = safeLog2(LEN),
  localparam int GW    = safeLog2(GROUPS)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output fir_strobe_t strb,
  output logic [OW-1:0] outIdx,
  output logic [GW-1:0] grpIdx,
  output logic        busy,
  output logic        done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t state;
  logic   drainCnt;   // the pipeline holds two stages after the final issue

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      outIdx   <= '0;
      grpIdx   <= '0;
      drainCnt <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_RUN;
            outIdx <= '0;
            grpIdx <= '0;
          end
        end
        S_RUN: begin
          if (grpIdx == GW'(GROUPS - 1)) begin
            grpIdx <= '0;
            if (outIdx == OW'(LEN - 1)) begin
              state    <= S_DRAIN;
              drainCnt <= 1'b0;
            end else begin
              outIdx <= outIdx + 1'b1;
            end
          end else begin
            grpIdx <= grpIdx + 1'b1;
          end
        end
        S_DRAIN: begin
          if (drainCnt) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            drainCnt <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    strb.issue = (state == S_RUN);
    strb.first = strb.issue && (grpIdx == '0);
    strb.last  = strb.issue && (grpIdx == GW'(GROUPS - 1));
  end

endmodule

// File: rtl/fir_datapath.sv
`timescale 1ns/1ps
module fir_datapath
  import fir_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TAPS   = 51,
  parameter int LEN    = 256,
  parameter int LANES  = 4,
  localparam int GROUPS = ceilDiv(TAPS, LANES),
  localparam int ROWS  = LEN / LANES,
  localparam int BW    = safeLog2(LANES),
  localparam int RW    = safeLog2(ROWS),
  localparam int AW    = safeLog2(LEN),
  localparam int CW    = safeLog2(TAPS),
  localparam int GW    = safeLog2(GROUPS),
  localparam int ACCW  = 2 * DW + $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            coefWe,
  input  logic [CW-1:0]   coefIdx,
  input  logic [DW-1:0]   coefData,
  input  logic            smpWe,
  input  logic [AW-1:0]   smpAddr,
  input  logic [DW-1:0]   smpData,
  input  fir_strobe_t     strb,
  input  logic [AW-1:0]   outIdx,
  input  logic [GW-1:0]   grpIdx,
  input  logic [AW-1:0]   rdAddr,
  output logic [ACCW-1:0] rdData
);

  // Weight register file
  logic signed [DW-1:0] coef [TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) coef[k] <= '0;
    end else if (coefWe && (int'(coefIdx) < TAPS)) begin
      coef[coefIdx] <= coefData;
    end
  end

  // Address generation for one tap group
  logic              laneOk   [LANES];
  logic [BW-1:0]     laneBank [LANES];
  logic [RW-1:0]     laneRow  [LANES];
  logic signed [DW-1:0] laneCoef [LANES];
  logic [RW-1:0]     bankRow  [LANES];

  always_comb begin
    int tI;
    int sI;
    for (int j = 0; j < LANES; j++) begin
      tI          = int'(grpIdx) * LANES + j;
      sI          = int'(outIdx) - tI;
      laneOk[j]   = (sI >= 0) && (tI < TAPS);
      laneBank[j] = BW'(sI);
      laneRow[j]  = laneOk[j] ? RW'(sI >> BW) : '0;
      laneCoef[j] = (tI < TAPS) ? coef[CW'(tI)] : '0;
    end
    // bank b serves the lane j whose sample index is congruent to b
    for (int b = 0; b < LANES; b++) begin
      bankRow[b] = laneRow[BW'(outIdx[BW-1:0] - BW'(b))];
    end
  end

  // Banked sample memory, one synchronous read per bank
  logic signed [DW-1:0] bankQ [LANES];

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic signed [DW-1:0] mem [ROWS];
    logic signed [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (smpWe && (smpAddr[BW-1:0] == BW'(b))) mem[smpAddr[AW-1:BW]] <= smpData;
      if (strb.issue) q <= mem[bankRow[b]];
    end
    assign bankQ[b] = q;
  end

  // Stage 1 registers
  logic                 validQ, firstQ, lastQ;
  logic [AW-1:0]        outIdxQ;
  logic                 laneOkQ   [LANES];
  logic [BW-1:0]        laneBankQ [LANES];
  logic signed [DW-1:0] coefQ     [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      firstQ <= 1'b0;
      lastQ  <= 1'b0;
    end else begin
      validQ <= strb.issue;
      firstQ <= strb.first;
      lastQ  <= strb.last;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.issue) begin
      outIdxQ <= outIdx;
      for (int j = 0; j < LANES; j++) begin
        laneOkQ[j]   <= laneOk[j];
        laneBankQ[j] <= laneBank[j];
        coefQ[j]     <= laneCoef[j];
      end
    end
  end

  // Stage 2: parallel products, adder tree, accumulate
  logic signed [ACCW-1:0] acc, sum, accNext;

  always_comb begin
    logic signed [DW-1:0]   xv;
    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] ext;
    sum = '0;
    for (int j = 0; j < LANES; j++) begin
      xv   = laneOkQ[j] ? bankQ[laneBankQ[j]] : '0;
      prod = xv * coefQ[j];
      ext  = prod;
      sum  = sum + ext;
    end
    accNext = (firstQ ? '0 : acc) + sum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (validQ) acc <= accNext;
  end

  // Result memory with registered read
  logic [ACCW-1:0] outMem [LEN];

  always_ff @(posedge clk) begin
    if (validQ && lastQ) outMem[outIdxQ] <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else rdData <= outMem[rdAddr];
  end

endmodule

// File: rtl/batch_fir.sv
`timescale 1ns/1ps
module batch_fir
  import fir_pkg::*;
#(
  parameter int DW    = 16,
  parameter int TAPS  = 51,
  parameter int LEN   = 256,
  parameter int LANES = 4,
  localparam int GROUPS = ceilDiv(TAPS, LANES),
  localparam int AW   = safeLog2(LEN),
  localparam int CW   = safeLog2(TAPS),
  localparam int GW   = safeLog2(GROUPS),
  localparam int ACCW = 2 * DW + $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            coefWe,
  input  logic [CW-1:0]   coefIdx,
  input  logic [DW-1:0]   coefData,
  input  logic            smpWe,
  input  logic [AW-1:0]   smpAddr,
  input  logic [DW-1:0]   smpData,
  input  logic            start,
  output logic            busy,
  output logic            done,
  input  logic [AW-1:0]   rdAddr,
  output logic [ACCW-1:0] rdData
);

  fir_strobe_t   strb;
  logic [AW-1:0] outIdx;
  logic [GW-1:0] grpIdx;

  fir_ctrl #(.LEN(LEN), .GROUPS(GROUPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb),
    .outIdx(outIdx), .grpIdx(grpIdx), .busy(busy), .done(done)
  );

  fir_datapath #(.DW(DW), .TAPS(TAPS), .LEN(LEN), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN),
    .coefWe(coefWe), .coefIdx(coefIdx), .coefData(coefData),
    .smpWe(smpWe), .smpAddr(smpAddr), .smpData(smpData),
    .strb(strb), .outIdx(outIdx), .grpIdx(grpIdx),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/batch_fir_chk.sv
`timescale 1ns/1ps
module batch_fir_chk #(
  parameter int LEN    = 256,
  parameter int TAPS   = 51,
  parameter int LANES  = 4,
  localparam int RUNCYC = LEN * ((TAPS + LANES - 1) / LANES) + 2
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);

  int busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= 0;
    else if (!busy) busyCnt <= 0;
    else busyCnt <= busyCnt + 1;
  end

  // R5: done lasts a single cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done never coincides with busy
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R6: busy only ends through done
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R6: an idle start is accepted on the next edge
  p_start_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R4, R5: a batch spans a fixed number of busy cycles, restarts included
  p_run_length_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == RUNCYC));

endmodule

bind batch_fir batch_fir_chk #(.LEN(LEN), .TAPS(TAPS), .LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done)
);

// File: tb/sim_batch_fir.sv
`timescale 1ns/1ps
module sim_batch_fir;

  localparam int TAPS = 51;
  localparam int LEN  = 256;
  localparam int LANES = 4;
  localparam int LAT  = LEN * ((TAPS + LANES - 1) / LANES) + 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coefWe = 1'b0;
  logic [5:0]  coefIdx = '0;
  logic [15:0] coefData = '0;
  logic        smpWe = 1'b0;
  logic [7:0]  smpAddr = '0;
  logic [15:0] smpData = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [7:0]  rdAddr = '0;
  logic [37:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  longint cf [TAPS];
  longint xs [LEN];

  always #2 clk = ~clk;

  batch_fir u0 (
    .clk(clk), .rstN(rstN), .coefWe(coefWe), .coefIdx(coefIdx), .coefData(coefData),
    .smpWe(smpWe), .smpAddr(smpAddr), .smpData(smpData), .start(start),
    .busy(busy), .done(done), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeCoef(input int idx, input longint val);
    @(negedge clk);
    coefWe = 1'b1; coefIdx = 6'(idx); coefData = 16'(val);
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic loadAll();
    for (int k = 0; k < TAPS; k++) writeCoef(k, cf[k]);
    for (int i = 0; i < LEN; i++) begin
      @(negedge clk);
      smpWe = 1'b1; smpAddr = 8'(i); smpData = 16'(xs[i]);
    end
    @(negedge clk);
    smpWe = 1'b0;
  endtask

  task automatic runBatch(input bit poke);
    int k;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    k = 1;
    @(negedge clk);
    start = 1'b0;
    check("R6", longint'(busy), 1, "busy after start");
    while (!done && k < LAT + 50) begin
      if (poke && k == 1000) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check("R5", longint'(k), longint'(LAT), "edges from start to done");
    if (poke) check("R4", longint'(k), longint'(LAT), "batch length with start while busy");
    check("R6", longint'(busy), 0, "busy at done");
    @(negedge clk);
    check("R5", longint'(done), 0, "done one cycle");
  endtask

  task automatic checkAll(input string req);
    longint exp;
    logic signed [37:0] a;
    for (int n = 0; n < LEN; n++) begin
      exp = 0;
      for (int t = 0; t < TAPS; t++) if (n - t >= 0) exp += cf[t] * xs[n - t];
      rdAddr = 8'(n);
      @(posedge clk);
      @(negedge clk);
      a = rdData;
      check(req, longint'(a), exp, $sformatf("R7 read of output %0d", n));
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lf;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", longint'(busy), 0, "busy after reset");
    check("R1", longint'(done), 0, "done after reset");
    check("R1", longint'(rdData), 0, "rdData after reset");

    // R8: unit impulse exposes tap ordering
    for (int k = 0; k < TAPS; k++) cf[k] = (k + 1) * 37 - 900;
    for (int i = 0; i < LEN; i++) xs[i] = (i == 0) ? 1 : 0;
    loadAll();
    runBatch(1'b0);
    checkAll("R8");

    // R2, R4, R9: pseudo-random operands, stray weight writes, start while busy
    lf = 32'h1ACE;
    for (int k = 0; k < TAPS; k++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      cf[k] = longint'(signed'(16'(lf >> 8)));
    end
    for (int i = 0; i < LEN; i++) begin
      lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
      xs[i] = longint'(signed'(16'(lf >> 8)));
    end
    loadAll();
    for (int k = TAPS; k < 64; k++) writeCoef(k, 16'h7abc);  // R9
    runBatch(1'b1);
    checkAll("R2 R4 R9");

    // R3: both operands at the negative extreme
    for (int k = 0; k < TAPS; k++) cf[k] = -32768;
    for (int i = 0; i < LEN; i++) xs[i] = -32768;
    loadAll();
    runBatch(1'b0);
    checkAll("R3");

    // R3: opposite-sign extremes give the most negative result
    for (int k = 0; k < TAPS; k++) cf[k] = 32767;
    loadAll();
    runBatch(1'b0);
    checkAll("R3");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule